// File: doc/BRIEF.md
# Terminal Address and Mode Decoder

This block sits behind the serial word decoder of a serial command/response bus terminal. The decoder hands it each received 16-bit word, a flag that says whether the word arrived with a command/status sync or a data sync, and a low-active valid-word level. While that level is low the block reports three decodes. The first says whether the word's address field names this terminal or the broadcast address. The second says whether the address field is the broadcast address. The third says whether the subaddress field marks a mode command. The terminal address comes in as a 5-bit strapped input.

The word is laid out MSB first. Bits 15:11 carry the terminal address. Bit 10 is transmit/receive. Bits 9:5 carry the subaddress. Bits 4:0 carry the word count or mode code. The three outputs follow the valid-word window exactly: they can only become active in the cycle the window opens, and they drop in the same cycle it closes. The decode result is taken from the word and sync type present in the first cycle of the window and is held for the rest of the window. Words that arrive with a data sync never raise any indication.

Top module: `tad_decoder`

## Requirements
- R1: While `word_ok_n` is low and the captured word had `rx_cmd_sync` = 1, `own_hit` is 1 when bits 15:11 of the captured word equal `term_addr` (bit 15 against `term_addr[4]`).
- R2: While `word_ok_n` is low and the captured word had `rx_cmd_sync` = 1, `bcast_n` is 0 exactly when bits 15:11 of the captured word are 5'b11111.
- R3: A broadcast word (bits 15:11 = 5'b11111, command sync, window open) drives `own_hit` to 1 whatever the value of `term_addr`.
- R4: While `word_ok_n` is low and the captured word had `rx_cmd_sync` = 1, `mode_n` is 0 exactly when bits 9:5 of the captured word are 5'b00000 or 5'b11111.
- R5: A word captured with `rx_cmd_sync` = 0 keeps `own_hit` at 0 and both `bcast_n` and `mode_n` at 1 for the whole window.
- R6: Whenever `word_ok_n` is high, `own_hit` is 0 and `bcast_n` and `mode_n` are 1. All three return to these values in the same cycle that `word_ok_n` rises.
- R7: The captured word and sync type are the values of `rx_word` and `rx_cmd_sync` in the first cycle of the window (the first low cycle of `word_ok_n` after a high cycle, or after reset). Changes to those inputs later in the same window do not change the outputs.
- R8: While `rst_n` is low, `own_hit` is 0 and `bcast_n` and `mode_n` are 1, even if `word_ok_n` is low and a matching word is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_word | input | 16 | Received word from the serial decoder |
| rx_cmd_sync | input | 1 | 1 = word arrived with command/status sync, 0 = data sync |
| word_ok_n | input | 1 | Valid-word level from the decoder, active low |
| term_addr | input | 5 | Strapped terminal address, bit 4 is the MSB |
| own_hit | output | 1 | Active high: the word is addressed to this terminal or is a broadcast |
| bcast_n | output | 1 | Active low: broadcast address received |
| mode_n | output | 1 | Active low: mode-command subaddress received |

## Verification
The hardest situation to reach from the ports is a word whose content and sync type change in the middle of an open window. A correct design must ignore that change, and a design that compares the inputs freely would follow it. The stimulus reaches this case by driving some windows that invert both the word and the sync flag after the first cycle, while the expected values stay those of the first-cycle word. Around this, the stimulus sweeps all 32 address values against all 32 subaddress values under both sync types with three different strapped addresses. It also holds the window open across reset release, so the first-cycle capture and the reset gating are both covered.

// File: rtl/tad_pkg.sv
package tad_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int SUB_W    = 5;
  localparam int ADDR_LSB = 11;
  localparam int SUB_LSB  = 5;

  typedef struct packed {
    logic hit;
    logic bcast;
    logic mode;
  } tad_flags_t;
endpackage

// File: rtl/tad_field_cmp.sv
module tad_field_cmp
  import tad_pkg::*;
#(
  parameter int P_WORD_W    = WORD_W,
  parameter int P_ADDR_W    = ADDR_W,
  parameter int P_SUB_W     = SUB_W,
  parameter int P_ADDR_LSB  = ADDR_LSB,
  parameter int P_SUB_LSB   = SUB_LSB,
  parameter bit P_MODE_ONES = 1'b1
) (
  input  logic [P_WORD_W-1:0] word,
  input  logic                cmd_sync,
  input  logic [P_ADDR_W-1:0] tadr,
  output tad_flags_t          flags
);
  localparam logic [P_ADDR_W-1:0] ADDR_ALL1 = '1;
  localparam logic [P_SUB_W-1:0]  SUB_ALL1  = '1;

  logic [P_ADDR_W-1:0] addr_f;
  logic [P_SUB_W-1:0]  sub_f;
  logic                addr_eq;
  logic                addr_bc;
  logic                sub_mode;

  assign addr_f  = word[P_ADDR_LSB +: P_ADDR_W];
  assign sub_f   = word[P_SUB_LSB +: P_SUB_W];
  assign addr_eq = (addr_f == tadr);
  assign addr_bc = (addr_f == ADDR_ALL1);

  generate
    if (P_MODE_ONES) begin : g_mode_both
      assign sub_mode = (sub_f == '0) || (sub_f == SUB_ALL1);
    end else begin : g_mode_zero
      assign sub_mode = (sub_f == '0);
    end
  endgenerate

  always_comb begin
    flags.hit   = cmd_sync & (addr_eq | addr_bc);
    flags.bcast = cmd_sync & addr_bc;
    flags.mode  = cmd_sync & sub_mode;
  end
endmodule

// File: rtl/tad_win_hold.sv
module tad_win_hold
  import tad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_ok_n,
  input  tad_flags_t fresh,
  output tad_flags_t live,
  output logic       open_edge
);
  logic       prev_q, prev_d;
  tad_flags_t held_q;
  logic       cap_en;

  always_comb begin
    open_edge = prev_q & ~word_ok_n;
    cap_en    = open_edge;
    prev_d    = word_ok_n;
    live      = open_edge ? fresh : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      held_q <= '0;
    end else begin
      prev_q <= prev_d;
      if (cap_en) begin
        held_q <= fresh;
      end
    end
  end

  // R7: inside an open window the held flags do not move
  a_r7_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_ok_n && !open_edge) |=> (held_q == $past(held_q)));
endmodule

// File: rtl/tad_decoder.sv
module tad_decoder
  import tad_pkg::*;
#(
  parameter int P_WORD_W    = WORD_W,
  parameter int P_ADDR_W    = ADDR_W,
  parameter int P_SUB_W     = SUB_W,
  parameter int P_ADDR_LSB  = ADDR_LSB,
  parameter int P_SUB_LSB   = SUB_LSB,
  parameter bit P_MODE_ONES = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_WORD_W-1:0] rx_word,
  input  logic                rx_cmd_sync,
  input  logic                word_ok_n,
  input  logic [P_ADDR_W-1:0] term_addr,
  output logic                own_hit,
  output logic                bcast_n,
  output logic                mode_n
);
  tad_flags_t fresh;
  tad_flags_t live;
  logic       open_edge;
  logic       win_on;

  tad_field_cmp #(
    .P_WORD_W   (P_WORD_W),
    .P_ADDR_W   (P_ADDR_W),
    .P_SUB_W    (P_SUB_W),
    .P_ADDR_LSB (P_ADDR_LSB),
    .P_SUB_LSB  (P_SUB_LSB),
    .P_MODE_ONES(P_MODE_ONES)
  ) u_cmp (
    .word    (rx_word),
    .cmd_sync(rx_cmd_sync),
    .tadr    (term_addr),
    .flags   (fresh)
  );

  tad_win_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_ok_n(word_ok_n),
    .fresh    (fresh),
    .live     (live),
    .open_edge(open_edge)
  );

  always_comb begin
    win_on  = rst_n & ~word_ok_n;
    own_hit = win_on & live.hit;
    bcast_n = ~(win_on & live.bcast);
    mode_n  = ~(win_on & live.mode);
  end

  // R6: closed window keeps every indication inactive
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok_n |-> (!own_hit && bcast_n && mode_n));

  // R3: broadcast always counts as a hit
  a_r3_bcast_hits: assert property (@(posedge clk) disable iff (!rst_n)
    !bcast_n |-> own_hit);

  // R1: own address with command sync at window opening gives a hit
  a_r1_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(word_ok_n) && $past(rst_n) && rx_cmd_sync &&
     rx_word[P_ADDR_LSB +: P_ADDR_W] == term_addr) |-> own_hit);

  // R5: data sync at window opening keeps everything quiet
  a_r5_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (open_edge && !rx_cmd_sync) |-> (!own_hit && bcast_n && mode_n));

  // R4: mode indication can only start when the window opens
  a_r4_mode_at_open: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mode_n) && $past(rst_n)) |-> $fell(word_ok_n));

  // R7: outputs frozen while a window stays open
  a_r7_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_ok_n && $past(!word_ok_n) && $past(rst_n)) |->
      ($stable(own_hit) && $stable(bcast_n) && $stable(mode_n)));
endmodule

// File: tb/tad_decoder_test.sv
module tad_decoder_test;
  localparam int CLK_PER = 10;

  typedef struct {
    logic  hit;
    logic  bc_n;
    logic  md_n;
    string why;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] rx_word;
  logic        rx_cmd_sync;
  logic        word_ok_n;
  logic [4:0]  term_addr;
  logic        own_hit;
  logic        bcast_n;
  logic        mode_n;

  int   checks;
  int   errors;
  exp_t sb_q[$];

  tad_decoder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_word    (rx_word),
    .rx_cmd_sync(rx_cmd_sync),
    .word_ok_n  (word_ok_n),
    .term_addr  (term_addr),
    .own_hit    (own_hit),
    .bcast_n    (bcast_n),
    .mode_n     (mode_n)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic exp_t model(input logic [15:0] w, input logic cs,
                                 input logic [4:0] ta, input string why);
    exp_t e;
    logic [4:0] a;
    logic [4:0] s;
    a = w[15:11];
    s = w[9:5];
    e.hit  = cs && ((a == ta) || (a == 5'h1f));
    e.bc_n = !(cs && (a == 5'h1f));
    e.md_n = !(cs && ((s == 5'h00) || (s == 5'h1f)));
    e.why  = why;
    return e;
  endfunction

  function automatic exp_t idle_exp();
    exp_t e;
    e.hit = 1'b0; e.bc_n = 1'b1; e.md_n = 1'b1; e.why = "R6";
    return e;
  endfunction

  task automatic check1(input string tag, input string nm,
                        input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %b exp %b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // driver: one window of len cycles, then one idle cycle
  task automatic drive_win(input logic [15:0] w, input logic cs,
                           input int len, input bit corrupt);
    string why;
    why = !cs ? "R5" : (corrupt ? "R7" :
          ((w[15:11] == 5'h1f) ? "R2 R3 R4" : "R1 R4"));
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_word     = (corrupt && i > 0) ? ~w : w;
      rx_cmd_sync = (corrupt && i > 0) ? ~cs : cs;
      word_ok_n   = 1'b0;
      sb_q.push_back(model(w, cs, term_addr, why));
    end
    @(negedge clk);
    word_ok_n   = 1'b1;
    rx_word     = ~w;
    rx_cmd_sync = 1'b1;
    sb_q.push_back(idle_exp());
  endtask

  // monitor: compare one expectation per cycle, away from the edge
  always begin
    @(negedge clk);
    #(CLK_PER/4);
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check1(e.why, "own_hit", own_hit, e.hit);
      check1(e.why, "bcast_n", bcast_n, e.bc_n);
      check1(e.why, "mode_n",  mode_n,  e.md_n);
    end
  end

  initial begin
    #(CLK_PER*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] taddrs [3];
    checks = 0;
    errors = 0;
    taddrs[0] = 5'h0d; taddrs[1] = 5'h00; taddrs[2] = 5'h1f;

    // R8: reset gates a matching open window
    rst_n       = 1'b0;
    term_addr   = 5'h0d;
    rx_word     = {5'h0d, 1'b0, 5'h00, 5'h03};
    rx_cmd_sync = 1'b1;
    word_ok_n   = 1'b0;
    repeat (3) @(negedge clk);
    #(CLK_PER/4);
    check1("R8", "own_hit", own_hit, 1'b0);
    check1("R8", "bcast_n", bcast_n, 1'b1);
    check1("R8", "mode_n",  mode_n,  1'b1);

    // R7: window already open at reset release is captured on first cycle
    @(negedge clk);
    rst_n = 1'b1;
    sb_q.push_back(model(rx_word, 1'b1, term_addr, "R7 R8"));
    @(negedge clk);
    rx_word = 16'h0000;
    sb_q.push_back(model({5'h0d, 1'b0, 5'h00, 5'h03}, 1'b1, term_addr, "R7"));
    @(negedge clk);
    word_ok_n = 1'b1;
    sb_q.push_back(idle_exp());

    // sweep address x subaddress x sync type for several strapped addresses
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      term_addr = taddrs[t];
      word_ok_n = 1'b1;
      sb_q.push_back(idle_exp());
      for (int a = 0; a < 32; a++) begin
        for (int s = 0; s < 32; s++) begin
          for (int c = 0; c < 2; c++) begin
            logic [15:0] w;
            w = {a[4:0], s[0], s[4:0], a[2:0] ^ s[2:0], c[0], s[4]};
            drive_win(w, c[0], 1 + ((a + s) % 2), 1'b0);
          end
        end
      end
    end

    // R7: mid-window change of word and sync type is ignored
    term_addr = 5'h0d;
    drive_win({5'h0d, 1'b1, 5'h00, 5'h04}, 1'b1, 4, 1'b1);
    drive_win({5'h1f, 1'b0, 5'h1f, 5'h00}, 1'b1, 3, 1'b1);
    drive_win({5'h12, 1'b0, 5'h0a, 5'h11}, 1'b1, 3, 1'b1);
    drive_win({5'h1f, 1'b0, 5'h00, 5'h00}, 1'b0, 3, 1'b1);
    drive_win({5'h0d, 1'b0, 5'h1f, 5'h00}, 1'b0, 5, 1'b1);

    // R6: long idle stretch with changing inputs
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_word     = {5'h1f, 1'b0, 5'h00, i[4:0]};
      rx_cmd_sync = 1'b1;
      word_ok_n   = 1'b1;
      sb_q.push_back(idle_exp());
    end

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule